// File: doc/BRIEF.md
# Phase-Selecting Clock and Data Recovery

This block recovers a bit strobe and retimed rail data from a bipolar line whose marks have already been sliced into two logic-level rails, one for positive marks and one for negative marks. A local reference clock runs at N times the nominal bit rate (N = 13 by default). The block cuts the reference-clock stream into bit windows. Each window is normally N samples long.

Within each window the block counts the mark samples that fall before the window centre and the mark samples that fall after it. If the pulse sits late, the next window is one sample longer (N+1). If it sits early, the next window is one sample shorter (N-1). So one correction changes one recovered bit period by exactly 1/N of a unit interval. This step is also the quantization jitter of the recovered strobe. A correction takes effect in the window right after the mark that caused it. There is no loop filter that would spread it over many bits.

A phase index counts the net corrections modulo N. A full turn of the index therefore means the recovered clock has gained or lost one whole bit against the nominal rate.

Top module: `cdr_phase_sel`

## Requirements
- R1: While rst_ni is low, bit_en_o, pos_o, neg_o and data_o are 0 and phase_o is 0. The first window after reset release is N samples long, so the first bit_en_o pulse appears N cycles after the first sampling edge.
- R2: bit_en_o is a one-cycle pulse. After a window that had no correction, the next pulse follows the previous one by exactly N cycles.
- R3: At each bit_en_o pulse, pos_o is 1 if pos_i was 1 in any sample of the window just closed, and 0 otherwise. neg_o follows the same rule for neg_i. data_o is pos_o OR neg_o. All three hold their values between pulses.
- R4: Sample positions in a window are numbered from 0. A window is "late" when it holds more mark samples (pos_i or neg_i) at positions above (N-1)/2 than below it. A late window makes the next window N+1 samples long and sets phase_o to (phase_o+1) mod N.
- R5: A window is "early" when it holds more mark samples below position (N-1)/2 than above it. An early window makes the next window N-1 samples long and sets phase_o to (phase_o-1) mod N.
- R6: A window with no marks, or with equal early and late counts, makes the next window N long and leaves phase_o unchanged.
- R7: phase_o changes only together with a bit_en_o pulse, and by at most one step, however far the pulse is from the centre.
- R8: phase_o stays below N. It wraps from N-1 to 0 on a late window and from 0 to N-1 on an early window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, N samples per nominal bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Sliced positive-mark rail |
| neg_i | input | 1 | Sliced negative-mark rail |
| bit_en_o | output | 1 | Recovered bit strobe, one cycle per window |
| pos_o | output | 1 | Retimed positive-rail bit |
| neg_o | output | 1 | Retimed negative-rail bit |
| data_o | output | 1 | Combined mark bit |
| phase_o | output | $clog2(N) | Selected phase index, modulo N |

## Verification
The bench builds the block with the default N = 13. At this value a run of thirteen late windows turns the phase index through a full circle and back to 0, and thirteen early windows turn it the other way. Both the N-1 to 0 wrap and the 0 to N-1 wrap are reached in a few hundred cycles. With the centre at position 6, the directed windows place marks wholly before, wholly after and straddling the centre, and the random windows mix all of these with per-sample noise on both rails.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_SLOW = 2'd1,
    STEP_FAST = 2'd2
  } step_e;
endpackage

// File: rtl/cdr_win_ctr.sv
module cdr_win_ctr
  import cdr_pkg::*;
#(
  parameter int N = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  step_e                step_i,
  output logic [$clog2(N+2)-1:0] idx_o,
  output logic                 last_o,
  output logic [$clog2(N)-1:0] phase_o
);
  localparam int CW = $clog2(N + 2);
  localparam int PW = $clog2(N);

  logic [CW-1:0] idx_q, len_q;
  logic [PW-1:0] ph_q;

  assign last_o  = (idx_q == len_q);
  assign idx_o   = idx_q;
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      len_q <= CW'(N - 1);
      ph_q  <= '0;
    end else if (last_o) begin
      idx_q <= '0;
      unique case (step_i)
        STEP_SLOW: begin
          len_q <= CW'(N);
          ph_q  <= (ph_q == PW'(N - 1)) ? '0 : ph_q + 1'b1;
        end
        STEP_FAST: begin
          len_q <= CW'(N - 2);
          ph_q  <= (ph_q == '0) ? PW'(N - 1) : ph_q - 1'b1;
        end
        default: len_q <= CW'(N - 1);
      endcase
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/cdr_phase_det.sv
module cdr_phase_det
  import cdr_pkg::*;
#(
  parameter int N = 13
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   mark_i,
  input  logic [$clog2(N+2)-1:0] idx_i,
  input  logic                   last_i,
  output step_e                  step_o
);
  localparam int CW  = $clog2(N + 2);
  localparam int MID = (N - 1) / 2;

  logic [CW-1:0] early_q, late_q, early_nxt, late_nxt;
  logic          hit_early, hit_late;

  assign hit_early = mark_i && (idx_i < CW'(MID));
  assign hit_late  = mark_i && (idx_i > CW'(MID));
  assign early_nxt = early_q + {{(CW-1){1'b0}}, hit_early};
  assign late_nxt  = late_q + {{(CW-1){1'b0}}, hit_late};

  always_comb begin
    step_o = STEP_HOLD;
    if (last_i) begin
      if (late_nxt > early_nxt)      step_o = STEP_SLOW;
      else if (early_nxt > late_nxt) step_o = STEP_FAST;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      early_q <= '0;
      late_q  <= '0;
    end else if (last_i) begin
      early_q <= '0;
      late_q  <= '0;
    end else begin
      early_q <= early_nxt;
      late_q  <= late_nxt;
    end
  end
endmodule

// File: rtl/cdr_rail_cap.sv
module cdr_rail_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic last_i,
  output logic bit_en_o,
  output logic pos_o,
  output logic neg_o,
  output logic data_o
);
  logic ps_q, ns_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q     <= 1'b0;
      ns_q     <= 1'b0;
      bit_en_o <= 1'b0;
      pos_o    <= 1'b0;
      neg_o    <= 1'b0;
      data_o   <= 1'b0;
    end else begin
      bit_en_o <= last_i;
      if (last_i) begin
        pos_o  <= ps_q | pos_i;
        neg_o  <= ns_q | neg_i;
        data_o <= ps_q | pos_i | ns_q | neg_i;
        ps_q   <= 1'b0;
        ns_q   <= 1'b0;
      end else begin
        ps_q <= ps_q | pos_i;
        ns_q <= ns_q | neg_i;
      end
    end
  end
endmodule

// File: rtl/cdr_phase_sel.sv
module cdr_phase_sel
  import cdr_pkg::*;
#(
  parameter int N = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pos_i,
  input  logic                 neg_i,
  output logic                 bit_en_o,
  output logic                 pos_o,
  output logic                 neg_o,
  output logic                 data_o,
  output logic [$clog2(N)-1:0] phase_o
);
  localparam int CW = $clog2(N + 2);

  logic [CW-1:0] idx;
  logic          last;
  step_e         step;

  cdr_win_ctr #(.N(N)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .idx_o   (idx),
    .last_o  (last),
    .phase_o (phase_o)
  );

  cdr_phase_det #(.N(N)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mark_i (pos_i | neg_i),
    .idx_i  (idx),
    .last_i (last),
    .step_o (step)
  );

  cdr_rail_cap u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pos_i    (pos_i),
    .neg_i    (neg_i),
    .last_i   (last),
    .bit_en_o (bit_en_o),
    .pos_o    (pos_o),
    .neg_o    (neg_o),
    .data_o   (data_o)
  );
endmodule

// File: rtl/cdr_phase_sel_chk.sv
module cdr_phase_sel_chk #(
  parameter int N = 13
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bit_en_o,
  input logic                 pos_o,
  input logic                 neg_o,
  input logic                 data_o,
  input logic [$clog2(N)-1:0] phase_o
);
  localparam int PW = $clog2(N);
  localparam int GW = $clog2(N + 4);

  logic [PW-1:0] prev_q, inc_ph, dec_ph;
  logic [GW-1:0] gap_q;
  logic          seen_q;

  assign inc_ph = (prev_q == PW'(N - 1)) ? '0 : prev_q + 1'b1;
  assign dec_ph = (prev_q == '0) ? PW'(N - 1) : prev_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= phase_o;
      if (bit_en_o) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);

  a_r3_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_o |-> ($stable(pos_o) && $stable(neg_o) && $stable(data_o)));

  a_r7_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != prev_q) |-> (bit_en_o && (phase_o == inc_ph || phase_o == dec_ph)));

  a_r8_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < PW'(N));

  // R4, R5, R6: window length stays within one sample of nominal
  a_r4_r5_window_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_o && seen_q) |-> (gap_q >= GW'(N - 1) && gap_q <= GW'(N + 1)));
endmodule

bind cdr_phase_sel cdr_phase_sel_chk #(.N(N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_o (bit_en_o),
  .pos_o    (pos_o),
  .neg_o    (neg_o),
  .data_o   (data_o),
  .phase_o  (phase_o)
);

// File: tb/sim_cdr_phase_sel.sv
module sim_cdr_phase_sel;
  localparam int N   = 13;
  localparam int PW  = $clog2(N);
  localparam int MID = (N - 1) / 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pos_i = 1'b0, neg_i = 1'b0;
  logic bit_en_o, pos_o, neg_o, data_o;
  logic [PW-1:0] phase_o;

  int vectors = 0, fails = 0;

  // reference state
  int m_idx, m_len, m_early, m_late, m_ph;
  bit m_ps, m_ns;
  bit e_en, e_pos, e_neg, e_dat;
  int e_ph;

  always #5 clk = ~clk;

  cdr_phase_sel #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pos_i(pos_i), .neg_i(neg_i),
    .bit_en_o(bit_en_o), .pos_o(pos_o), .neg_o(neg_o), .data_o(data_o),
    .phase_o(phase_o)
  );

  function automatic int wrap_ph(int p);
    return (p + N) % N;
  endfunction

  task automatic model_reset();
    m_idx = 0; m_len = N; m_early = 0; m_late = 0; m_ph = 0;
    m_ps = 0; m_ns = 0;
    e_en = 0; e_pos = 0; e_neg = 0; e_dat = 0; e_ph = 0;
  endtask

  // R3-R6: one reference sample step
  task automatic model_step(bit p, bit n);
    bit mk = p | n;
    if (mk && m_idx < MID) m_early++;
    if (mk && m_idx > MID) m_late++;
    m_ps |= p;
    m_ns |= n;
    if (m_idx == m_len - 1) begin
      e_en = 1; e_pos = m_ps; e_neg = m_ns; e_dat = m_ps | m_ns;
      if (m_late > m_early) begin m_len = N + 1; m_ph = wrap_ph(m_ph + 1); end
      else if (m_early > m_late) begin m_len = N - 1; m_ph = wrap_ph(m_ph - 1); end
      else m_len = N;
      e_ph = m_ph;
      m_idx = 0; m_early = 0; m_late = 0; m_ps = 0; m_ns = 0;
    end else begin
      e_en = 0;
      m_idx++;
    end
  endtask

  task automatic check(string tag);
    vectors++;
    if (bit_en_o !== e_en || pos_o !== e_pos || neg_o !== e_neg ||
        data_o !== e_dat || phase_o !== PW'(e_ph)) begin
      fails++;
      $display("FAIL %s: got en=%b pos=%b neg=%b dat=%b ph=%0d exp en=%b pos=%b neg=%b dat=%b ph=%0d",
               tag, bit_en_o, pos_o, neg_o, data_o, phase_o,
               e_en, e_pos, e_neg, e_dat, e_ph);
    end
  endtask

  task automatic tick(bit p, bit n, string tag);
    pos_i = p; neg_i = n;
    model_step(p, n);
    @(negedge clk);
    check(tag);
  endtask

  // kind: 0 space, 1 late, 2 early, 3 centred, 4 noise, 5 wide late hit
  task automatic drive_win(int kind, bit use_neg, string tag);
    bit last, mk, p, n;
    do begin
      last = (m_idx == m_len - 1);
      case (kind)
        1: mk = (m_idx >= MID + 2) && (m_idx <= MID + 5);
        2: mk = (m_idx >= 1) && (m_idx <= MID - 2);
        3: mk = (m_idx >= MID - 2) && (m_idx <= MID + 2);
        4: mk = ($urandom_range(0, 2) == 0);
        5: mk = (m_idx == N - 1) || (m_idx == N);
        default: mk = 1'b0;
      endcase
      if (kind == 4) begin
        p = mk & $urandom_range(0, 1);
        n = mk & !p;
      end else begin
        p = mk & !use_neg;
        n = mk & use_neg;
      end
      tick(p, n, tag);
    end while (!last);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0013));
    model_reset();
    pos_i = 1'b1; neg_i = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R1 reset state");
    end
    pos_i = 1'b0; neg_i = 1'b0;
    rst_ni = 1'b1;
    model_reset();

    // R1, R2, R6: empty windows at nominal length
    drive_win(0, 0, "R1 first window");
    drive_win(0, 0, "R2 nominal period");
    drive_win(3, 0, "R6 centred pulse");
    drive_win(3, 1, "R3 centred neg rail");
    // R4: late pulse lengthens the next window
    drive_win(1, 0, "R4 late pulse");
    drive_win(0, 0, "R4 lengthened window");
    // R5: early pulse shortens the next window
    drive_win(2, 1, "R5 early pulse");
    drive_win(0, 0, "R5 shortened window");
    // R3: both rails in one window
    begin
      bit last;
      do begin
        last = (m_idx == m_len - 1);
        tick(m_idx == 3, m_idx == 9, "R3 both rails");
      end while (!last);
    end
    drive_win(0, 0, "R3 rails clear");
    // R7: far-late hit still moves one step
    drive_win(5, 0, "R7 large hit");
    drive_win(0, 0, "R7 after hit");
    // R8: wrap upward then downward
    for (int k = 0; k < N + 1; k++) drive_win(1, k[0], "R8 wrap up");
    for (int k = 0; k < 2 * N + 1; k++) drive_win(2, k[0], "R8 wrap down");
    // mixed random windows
    for (int k = 0; k < 600; k++)
      drive_win($urandom_range(0, 5), $urandom_range(0, 1), "R3-R7 random");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule